// File: doc/BRIEF.md
# Status Word and Exception Request Controller

This block keeps the low half of a processor status word: four condition flags (carry, overflow, zero, negative) and four enables (trace, decimal-overflow trap, floating-underflow fault, integer-overflow trap). It also keeps a trace-pending flag. At the end of each instruction the execution pipeline gives it a summary of the result: the value, a carry/borrow bit, overflow and conversion-error bits, an operation class, and divide-by-zero, floating-overflow and floating-underflow indications. It also gives one mask bit for each flag.

From this summary the block updates the flags that the mask selects. It then decides whether a trap or fault is owed. Arithmetic overflow always sets V, but it asks for a trap only when the matching enable bit is set. Divide-by-zero and floating overflow always raise a request. Trace is a two-step mechanism. When an instruction starts, T is copied into the pending flag. When that instruction ends with the pending flag set, a trace fault is requested.

Two more ports change the enables. A procedure-entry port loads the two overflow enables, clears the underflow enable and leaves T alone. A parallel load port overwrites the whole word when a context is restored. The current word is always visible on a read port.

Top module: `psw_trap_ctl`

## Requirements
- R1: After reset the status word reads 0, the trace-pending flag is 0 and no request is raised.
- R2: Status bits are C=0, V=1, Z=2, N=3, T=4, DV=5, FU=6, IV=7, and bits 15:8 always read 0. When load_en is high, bits 7:0 of load_word become the word at the next edge, and this wins over every other update in that cycle.
- R3: On res_valid, each flag whose upd_mask bit is 1 is updated (mask bit index = flag bit index): C takes res_carry, Z is set when res_value is zero, and N takes the top bit of res_value. Flags whose mask bit is 0 keep their value.
- R4: On res_valid with mask bit 1 set, V becomes res_ovf OR res_cvt_err, whatever the enable bits are.
- R5: Class encoding is 0 integer, 1 decimal, 2 float, 3 other. An integer result with overflow or conversion error requests cause bit 4 only if IV is 1. A decimal result with overflow or conversion error requests cause bit 5 only if DV is 1.
- R6: A float result with res_funf requests cause bit 2 only if FU is 1.
- R7: res_divzero always raises a request. For class float it is cause bit 0; for integer and decimal it is cause bit 3.
- R8: A float result with res_fovf always requests cause bit 1.
- R9: ins_start copies T into the trace-pending flag. A res_valid seen while the flag is set requests cause bit 6 and clears the flag, unless ins_start is high in the same cycle and reloads it.
- R10: The request is registered. req_valid is high in the cycle after res_valid only, and req_cause is one-hot and selects the lowest-numbered pending cause (faults 0..2, then traps 3..5, then trace 6). Without a request req_cause reads 0.
- R11: On call_entry, IV takes call_iv, DV takes call_dv, FU is cleared, and T and the condition flags keep their values unless res_valid updates the flags in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_start | input | 1 | An instruction begins; sample T into trace-pending |
| res_valid | input | 1 | Instruction ends; result summary below is valid |
| res_value | input | DATA_W | Result value |
| res_carry | input | 1 | Carry out of or borrow into the top bit |
| res_ovf | input | 1 | Result too large for its destination |
| res_cvt_err | input | 1 | Conversion error |
| res_class | input | 2 | 0 integer, 1 decimal, 2 float, 3 other |
| res_divzero | input | 1 | Zero divisor |
| res_fovf | input | 1 | Floating result too large |
| res_funf | input | 1 | Floating result too small |
| upd_mask | input | 4 | Per-flag update enables, indexed like bits 3:0 |
| call_entry | input | 1 | Procedure-entry enable update |
| call_iv | input | 1 | New IV on procedure entry |
| call_dv | input | 1 | New DV on procedure entry |
| load_en | input | 1 | Restore the whole word |
| load_word | input | 16 | Word to restore |
| psw_out | output | 16 | Current status word |
| tp_out | output | 1 | Trace-pending flag |
| req_valid | output | 1 | Trap or fault request strobe |
| req_cause | output | 7 | One-hot cause of the request |

## Verification
Directed results first set each enable to 0 and then to 1 under the same overflow, underflow and divide-by-zero inputs. This separates the gated causes from the ones that always fire, and float from integer division. Results that raise several causes at once, for example a divide trap together with a pending trace, or float overflow together with underflow, show whether the priority order holds. Random result summaries with mixed masks, loads and procedure entries are compared each cycle against a bench model of the word, the pending flag and the request. Zero and negative values are injected on purpose so that the Z and N paths are each taken both ways.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int PSW_W    = 16;
   localparam int PSW_USED = 8;
   localparam int CC_W     = 4;

   localparam int B_C  = 0;
   localparam int B_V  = 1;
   localparam int B_Z  = 2;
   localparam int B_N  = 3;
   localparam int B_T  = 4;
   localparam int B_DV = 5;
   localparam int B_FU = 6;
   localparam int B_IV = 7;

   localparam int NCAUSE = 7;
   localparam int K_FDZ  = 0;
   localparam int K_FOV  = 1;
   localparam int K_FUN  = 2;
   localparam int K_DZ   = 3;
   localparam int K_IOV  = 4;
   localparam int K_DOV  = 5;
   localparam int K_TRC  = 6;

   typedef enum logic [1:0] {
      CLS_INT = 2'd0,
      CLS_DEC = 2'd1,
      CLS_FLT = 2'd2,
      CLS_OTH = 2'd3
   } op_class_e;
endpackage

// File: rtl/psw_cc_unit.sv
module psw_cc_unit
   import psw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   input  logic              carry,
   input  logic              ovf,
   input  logic              cvt_err,
   input  logic [CC_W-1:0]   mask,
   input  logic [CC_W-1:0]   cc_old,
   output logic [CC_W-1:0]   cc_new
);
   logic [CC_W-1:0] calc;

   always_comb begin
      calc        = '0;
      calc[B_C]   = carry;
      calc[B_V]   = ovf | cvt_err;
      calc[B_Z]   = (value == '0);
      calc[B_N]   = value[DATA_W-1];
   end

   for (genvar i = 0; i < CC_W; i++) begin : g_sel
      assign cc_new[i] = mask[i] ? calc[i] : cc_old[i];
   end
endmodule

// File: rtl/psw_exc_detect.sv
module psw_exc_detect
   import psw_pkg::*;
(
   input  logic [1:0]        cls,
   input  logic              divz,
   input  logic              fovf,
   input  logic              funf,
   input  logic              ovf,
   input  logic              cvt_err,
   input  logic              iv_en,
   input  logic              dv_en,
   input  logic              fu_en,
   input  logic              trace_pend,
   output logic [NCAUSE-1:0] raw
);
   op_class_e c;
   logic      bad_range;

   always_comb begin
      c         = op_class_e'(cls);
      bad_range = ovf | cvt_err;
      raw       = '0;
      unique case (c)
         CLS_FLT: begin
            raw[K_FDZ] = divz;
            raw[K_FOV] = fovf;
            raw[K_FUN] = funf & fu_en;
         end
         CLS_INT: begin
            raw[K_DZ]  = divz;
            raw[K_IOV] = bad_range & iv_en;
         end
         CLS_DEC: begin
            raw[K_DZ]  = divz;
            raw[K_DOV] = bad_range & dv_en;
         end
         default: ;
      endcase
      raw[K_TRC] = trace_pend;
   end
endmodule

// File: rtl/psw_prio_pick.sv
module psw_prio_pick #(
   parameter int N = 7
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/psw_trap_ctl.sv
module psw_trap_ctl
   import psw_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter bit HAS_TRACE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_start,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_value,
   input  logic              res_carry,
   input  logic              res_ovf,
   input  logic              res_cvt_err,
   input  logic [1:0]        res_class,
   input  logic              res_divzero,
   input  logic              res_fovf,
   input  logic              res_funf,
   input  logic [3:0]        upd_mask,
   input  logic              call_entry,
   input  logic              call_iv,
   input  logic              call_dv,
   input  logic              load_en,
   input  logic [15:0]       load_word,
   output logic [15:0]       psw_out,
   output logic              tp_out,
   output logic              req_valid,
   output logic [6:0]        req_cause
);
   localparam int PAD_W = PSW_W - PSW_USED;

   if (DATA_W < 2) begin : g_bad_width
      $error("psw_trap_ctl: DATA_W must be at least 2");
   end
   if (NCAUSE != 7 || PSW_W != 16) begin : g_bad_pkg
      $error("psw_trap_ctl: package constants do not match the port widths");
   end

   logic [PSW_USED-1:0] st_q, st_d;
   logic                tp_q, tp_d;
   logic                rq_q;
   logic [NCAUSE-1:0]   cause_q;
   logic [CC_W-1:0]     cc_new;
   logic [NCAUSE-1:0]   raw, grant;
   logic                any;

   psw_cc_unit #(.DATA_W(DATA_W)) u_cc (
      .value   (res_value),
      .carry   (res_carry),
      .ovf     (res_ovf),
      .cvt_err (res_cvt_err),
      .mask    (upd_mask),
      .cc_old  (st_q[CC_W-1:0]),
      .cc_new  (cc_new)
   );

   psw_exc_detect u_det (
      .cls        (res_class),
      .divz       (res_divzero),
      .fovf       (res_fovf),
      .funf       (res_funf),
      .ovf        (res_ovf),
      .cvt_err    (res_cvt_err),
      .iv_en      (st_q[B_IV]),
      .dv_en      (st_q[B_DV]),
      .fu_en      (st_q[B_FU]),
      .trace_pend (tp_q),
      .raw        (raw)
   );

   psw_prio_pick #(.N(NCAUSE)) u_pick (
      .req   (raw),
      .grant (grant),
      .any   (any)
   );

   always_comb begin
      st_d = st_q;
      if (res_valid) st_d[CC_W-1:0] = cc_new;
      if (call_entry) begin
         st_d[B_IV] = call_iv;
         st_d[B_DV] = call_dv;
         st_d[B_FU] = 1'b0;
      end
      if (load_en) st_d = load_word[PSW_USED-1:0];
   end

   if (HAS_TRACE) begin : g_trace
      always_comb begin
         if (ins_start)      tp_d = st_q[B_T];
         else if (res_valid) tp_d = 1'b0;
         else                tp_d = tp_q;
      end
   end else begin : g_no_trace
      assign tp_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= '0;
         tp_q    <= 1'b0;
         rq_q    <= 1'b0;
         cause_q <= '0;
      end else begin
         st_q    <= st_d;
         tp_q    <= tp_d;
         rq_q    <= res_valid & any;
         cause_q <= res_valid ? grant : '0;
      end
   end

   assign psw_out   = {{PAD_W{1'b0}}, st_q};
   assign tp_out    = tp_q;
   assign req_valid = rq_q;
   assign req_cause = cause_q;
endmodule

// File: rtl/psw_trap_chk.sv
module psw_trap_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ins_start,
   input logic        res_valid,
   input logic        res_ovf,
   input logic [1:0]  res_class,
   input logic        res_divzero,
   input logic        res_fovf,
   input logic [3:0]  upd_mask,
   input logic        call_entry,
   input logic        load_en,
   input logic [15:0] load_word,
   input logic [15:0] psw_out,
   input logic        tp_out,
   input logic        req_valid,
   input logic [6:0]  req_cause
);
   // R2
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psw_out[15:8] == 8'h00);

   // R2
   load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en |=> psw_out[7:0] == $past(load_word[7:0]));

   // R4
   v_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && upd_mask[1] && res_ovf && !load_en) |=> psw_out[1]);

   // R7
   divzero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_divzero && res_class != 2'd3) |=> req_valid);

   // R8
   fovf_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fovf && res_class == 2'd2) |=> req_valid);

   // R9
   trace_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && tp_out) |=> (req_valid && req_cause != 7'd0));

   // R9
   trace_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !ins_start) |=> !tp_out);

   // R10
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $countones(req_cause) == 1);

   // R10
   req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> (!req_valid && req_cause == 7'd0));

   // R11
   call_fu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_entry && !load_en) |=> !psw_out[6]);
endmodule

bind psw_trap_ctl psw_trap_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ins_start   (ins_start),
   .res_valid   (res_valid),
   .res_ovf     (res_ovf),
   .res_class   (res_class),
   .res_divzero (res_divzero),
   .res_fovf    (res_fovf),
   .upd_mask    (upd_mask),
   .call_entry  (call_entry),
   .load_en     (load_en),
   .load_word   (load_word),
   .psw_out     (psw_out),
   .tp_out      (tp_out),
   .req_valid   (req_valid),
   .req_cause   (req_cause)
);

// File: tb/psw_trap_ctl_tb.sv
module psw_trap_ctl_tb;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ins_start, res_valid, res_carry, res_ovf, res_cvt_err;
   logic [DW-1:0] res_value;
   logic [1:0]    res_class;
   logic          res_divzero, res_fovf, res_funf;
   logic [3:0]    upd_mask;
   logic          call_entry, call_iv, call_dv, load_en;
   logic [15:0]   load_word;
   logic [15:0]   psw_out;
   logic          tp_out, req_valid;
   logic [6:0]    req_cause;

   int errs = 0;
   int checks = 0;
   logic [7:0] m_st;
   logic       m_tp;
   logic       m_rq;
   logic [6:0] m_cause;

   always #10 clk = ~clk;

   psw_trap_ctl #(.DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .ins_start(ins_start), .res_valid(res_valid),
      .res_value(res_value), .res_carry(res_carry), .res_ovf(res_ovf),
      .res_cvt_err(res_cvt_err), .res_class(res_class), .res_divzero(res_divzero),
      .res_fovf(res_fovf), .res_funf(res_funf), .upd_mask(upd_mask),
      .call_entry(call_entry), .call_iv(call_iv), .call_dv(call_dv),
      .load_en(load_en), .load_word(load_word), .psw_out(psw_out),
      .tp_out(tp_out), .req_valid(req_valid), .req_cause(req_cause)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      ins_start = 0; res_valid = 0; res_value = '0; res_carry = 0; res_ovf = 0;
      res_cvt_err = 0; res_class = 2'd3; res_divzero = 0; res_fovf = 0;
      res_funf = 0; upd_mask = 4'h0; call_entry = 0; call_iv = 0; call_dv = 0;
      load_en = 0; load_word = '0;
   endtask

   // causes a result summary must raise, from R5..R9
   function automatic logic [6:0] want_raw();
      logic [6:0] r = '0;
      logic bad = res_ovf | res_cvt_err;
      case (res_class)
         2'd2: begin r[0] = res_divzero; r[1] = res_fovf; r[2] = res_funf & m_st[6]; end
         2'd0: begin r[3] = res_divzero; r[4] = bad & m_st[7]; end
         2'd1: begin r[3] = res_divzero; r[5] = bad & m_st[5]; end
         default: ;
      endcase
      r[6] = m_tp;
      return r;
   endfunction

   function automatic logic [6:0] lowest(input logic [6:0] r);
      for (int i = 0; i < 7; i++) if (r[i]) return 7'(1) << i;
      return '0;
   endfunction

   task automatic step();
      logic [7:0] ns = m_st;
      logic       ntp;
      logic [6:0] r = want_raw();
      if (res_valid) begin
         if (upd_mask[0]) ns[0] = res_carry;
         if (upd_mask[1]) ns[1] = res_ovf | res_cvt_err;
         if (upd_mask[2]) ns[2] = (res_value == '0);
         if (upd_mask[3]) ns[3] = res_value[DW-1];
      end
      if (call_entry) begin ns[7] = call_iv; ns[5] = call_dv; ns[6] = 1'b0; end
      if (load_en) ns = load_word[7:0];
      ntp = ins_start ? m_st[4] : (res_valid ? 1'b0 : m_tp);
      @(posedge clk);
      @(negedge clk);
      m_rq    = res_valid && (r != '0);
      m_cause = res_valid ? lowest(r) : '0;
      m_st    = ns;
      m_tp    = ntp;
      chk(psw_out[15:8] == 8'h00, "R2", "upper bits", 32'(psw_out[15:8]), 0);
      chk({psw_out[3:2], psw_out[0]} == {m_st[3:2], m_st[0]}, "R3", "N/Z/C",
          32'(psw_out[3:0]), 32'(m_st[3:0]));
      chk(psw_out[1] == m_st[1], "R4", "V flag", 32'(psw_out[1]), 32'(m_st[1]));
      chk(psw_out[7:4] == m_st[7:4], "R11", "enable bits", 32'(psw_out[7:4]), 32'(m_st[7:4]));
      chk(tp_out == m_tp, "R9", "trace pending", 32'(tp_out), 32'(m_tp));
      chk({req_valid, req_cause} == {m_rq, m_cause}, "R10", "request",
          32'({req_valid, req_cause}), 32'({m_rq, m_cause}));
      idle();
   endtask

   task automatic load(input logic [15:0] w);
      load_en = 1; load_word = w; step();
   endtask

   task automatic result(input logic [1:0] cls, input logic ov, input logic dz,
                         input logic fo, input logic fu);
      res_valid = 1; res_class = cls; res_ovf = ov; res_divzero = dz;
      res_fovf = fo; res_funf = fu; res_value = 32'h1; step();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errs++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'h5a17));
      idle();
      m_st = '0; m_tp = 0; m_rq = 0; m_cause = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk(psw_out == 16'h0, "R1", "word after reset", 32'(psw_out), 0);
      chk(tp_out == 0 && req_valid == 0, "R1", "pending/request after reset",
          32'({tp_out, req_valid}), 0);

      // R2 load with upper bits set
      load(16'hFFFF);
      chk(psw_out == 16'h00FF, "R2", "load readback", 32'(psw_out), 32'h00FF);

      // R4/R5 overflow with IV=0: V set, no trap
      load(16'h0000);
      upd_mask = 4'b0010; result(2'd0, 1, 0, 0, 0);
      chk(psw_out[1] == 1, "R4", "V on masked overflow", 32'(psw_out[1]), 1);
      chk(req_valid == 0, "R5", "no trap with IV=0", 32'(req_valid), 0);
      res_cvt_err = 1; result(2'd1, 0, 0, 0, 0);
      chk(req_valid == 0, "R5", "no trap with DV=0", 32'(req_valid), 0);
      load(16'h00A0);
      result(2'd0, 1, 0, 0, 0);
      chk(req_cause == 7'h10, "R5", "integer overflow trap", 32'(req_cause), 32'h10);
      res_cvt_err = 1; result(2'd1, 0, 0, 0, 0);
      chk(req_cause == 7'h20, "R5", "decimal conversion trap", 32'(req_cause), 32'h20);

      // R7 divide by zero, no enable involved
      load(16'h0000);
      result(2'd2, 0, 1, 0, 0);
      chk(req_cause == 7'h01, "R7", "float divide fault", 32'(req_cause), 32'h01);
      result(2'd0, 0, 1, 0, 0);
      chk(req_cause == 7'h08, "R7", "integer divide trap", 32'(req_cause), 32'h08);
      result(2'd1, 0, 1, 0, 0);
      chk(req_cause == 7'h08, "R7", "decimal divide trap", 32'(req_cause), 32'h08);

      // R6/R8 float range
      load(16'h0040);
      result(2'd2, 0, 0, 1, 1);
      chk(req_cause == 7'h02, "R8", "overflow beats underflow", 32'(req_cause), 32'h02);
      result(2'd2, 0, 0, 0, 1);
      chk(req_cause == 7'h04, "R6", "underflow with FU=1", 32'(req_cause), 32'h04);
      load(16'h0000);
      result(2'd2, 0, 0, 0, 1);
      chk(req_valid == 0, "R6", "underflow with FU=0", 32'(req_valid), 0);
      result(2'd2, 0, 0, 1, 0);
      chk(req_cause == 7'h02, "R8", "overflow with no enables", 32'(req_cause), 32'h02);

      // R3 zero, negative, masked-off
      res_valid = 1; upd_mask = 4'hF; res_value = '0; res_carry = 1; step();
      chk(psw_out[3:0] == 4'b0101, "R3", "zero with carry", 32'(psw_out[3:0]), 32'h5);
      res_valid = 1; upd_mask = 4'hF; res_value = 32'h8000_0000; step();
      chk(psw_out[3:0] == 4'b1000, "R3", "negative", 32'(psw_out[3:0]), 32'h8);
      res_valid = 1; upd_mask = 4'h0; res_value = '0; res_carry = 1; step();
      chk(psw_out[3:0] == 4'b1000, "R3", "masked flags hold", 32'(psw_out[3:0]), 32'h8);

      // R9/R10 trace
      load(16'h0010);
      ins_start = 1; step();
      chk(tp_out == 1, "R9", "T copied to pending", 32'(tp_out), 1);
      result(2'd3, 0, 0, 0, 0);
      chk(req_cause == 7'h40 && tp_out == 0, "R9", "trace request and clear",
          32'({tp_out, req_cause}), 32'h40);
      ins_start = 1; step();
      result(2'd0, 0, 1, 0, 0);
      chk(req_cause == 7'h08, "R10", "trap beats trace", 32'(req_cause), 32'h08);

      // R11 procedure entry
      load(16'h00FF);
      call_entry = 1; call_iv = 0; call_dv = 1; step();
      chk(psw_out == 16'h003F, "R11", "entry enables", 32'(psw_out), 32'h3F);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         load_en     = ($urandom % 16) == 0;
         load_word   = 16'($urandom);
         call_entry  = ($urandom % 8) == 0;
         call_iv     = 1'($urandom);
         call_dv     = 1'($urandom);
         ins_start   = 1'($urandom);
         res_valid   = 1'($urandom);
         res_class   = 2'($urandom);
         res_carry   = 1'($urandom);
         res_ovf     = ($urandom % 4) == 0;
         res_cvt_err = ($urandom % 6) == 0;
         res_divzero = ($urandom % 8) == 0;
         res_fovf    = ($urandom % 6) == 0;
         res_funf    = ($urandom % 4) == 0;
         upd_mask    = 4'($urandom);
         case ($urandom % 3)
            0: res_value = '0;
            1: res_value = 32'h8000_0000 | 32'($urandom);
            default: res_value = 32'($urandom);
         endcase
         step();
      end

      summary();
      $finish;
   end
endmodule